// File: doc/BRIEF.md
# Index Load and Reset Control

This block sits beside the position counter of one encoder axis and decides, cycle by cycle, whether that counter is loaded from its preset, reset to zero, or allowed to count, and whether the snapshot latch copies the counter. It does so by reading two asynchronous control pins. The configuration bits give each pin one of several functions. The load pin can drive a counter load or a latch load, either as a plain level or tied to the encoder index. The reset pin can drive a counter reset as a level or tied to the index, act as a count gate, or do nothing.

Both pins pass through a synchroniser before use. The level-driven functions always treat a low pin as active. The index-tied functions use a programmable active level. They fire a single one-cycle pulse on the first quadrature count event seen while the index is active. They stay quiet until the index has gone inactive again, so an index pulse one quadrature state wide and one two states wide each give exactly one action. When the channel is not in quadrature mode, the index-tied functions are switched off. A reset request always beats a counter-load request in the same cycle.

Top module: `index_ctl`

## Requirements
- R1: While `rst_n` is low, `cnt_load`, `ol_load` and `cnt_reset` are 0 and `cnt_en` is 0.
- R2: With `cfg_ld_mode` = 2'b00 (level counter load), `cnt_load` is 1 in every cycle in which the synchronised `ld_pin` is low. It rises on the third rising clock edge after the pin falls and clears three edges after the pin rises. `ol_load` stays 0.
- R3: With `cfg_ld_mode` = 2'b01 (level latch load), `ol_load` follows a low `ld_pin` with the same three-edge latency, and `cnt_load` stays 0.
- R4: With `cfg_ld_mode` = 2'b10 (index counter load) or 2'b11 (index latch load) and `cfg_quad` = 1, `cnt_load` or `ol_load` respectively is 1 for one cycle, right after the edge on which `qevt` is 1 while the synchronised `ld_pin` is at its active level. Without `qevt`, nothing fires.
- R5: An index-tied function fires at most once per index assertion. Further `qevt` pulses give nothing until the synchronised pin has been inactive for at least one cycle.
- R6: In the index-tied modes the active level is high when `cfg_idx_pol` = 1 and low when it is 0. The level-driven modes ignore `cfg_idx_pol` and act on low only.
- R7: With `cfg_rs_mode` = 2'b00, `cnt_reset` follows a low `rs_pin` with three-edge latency. With 2'b10 and `cfg_quad` = 1, `cnt_reset` is a one-cycle index-tied pulse under the rules of R4 to R6.
- R8: With `cfg_rs_mode` = 2'b01 (gate), `cnt_en` equals the synchronised `rs_pin`, with three-edge latency, and `cnt_reset` stays 0. In every other reset mode, `cnt_en` is 1.
- R9: With `cfg_quad` = 0, the index-tied modes produce no `cnt_load`, `ol_load` or `cnt_reset`.
- R10: When a reset request and a counter-load request coincide, `cnt_reset` is 1 and `cnt_load` is 0. `ol_load` is unaffected.
- R11: With `cfg_rs_mode` = 2'b11 the reset pin has no function: `cnt_reset` stays 0 and `cnt_en` stays 1 whatever the pin does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_pin | input | 1 | Asynchronous load/index pin |
| rs_pin | input | 1 | Asynchronous reset/gate/index pin |
| cfg_ld_mode | input | 2 | Load pin function: 00 level counter load, 01 level latch load, 10 index counter load, 11 index latch load |
| cfg_rs_mode | input | 2 | Reset pin function: 00 level reset, 01 gate, 10 index reset, 11 none |
| cfg_idx_pol | input | 1 | Active level of the index-tied modes (1 = high) |
| cfg_quad | input | 1 | Channel in quadrature mode |
| qevt | input | 1 | One-cycle quadrature count event strobe |
| cnt_load | output | 1 | Load counter from preset |
| ol_load | output | 1 | Copy counter into output latch |
| cnt_reset | output | 1 | Clear counter |
| cnt_en | output | 1 | Counter enable |

## Verification
A pin change made between edges is seen by the level-driven results and the gate on the third rising edge after it. The checks therefore wait three edges and then sample on the falling edge, and they also sample after only two edges to confirm that nothing arrives early. Index-tied results need the pin to have passed both synchroniser stages, which takes two edges. The bench then raises `qevt` for one cycle and expects the pulse on the falling edge right after that edge. It checks the pulse is gone one cycle later. Every stimulus is applied on a falling edge, so inputs never change at a sampling edge.

// File: rtl/index_ctl_pkg.sv
package index_ctl_pkg;

  typedef enum logic [1:0] {
    LD_LVL_CNT = 2'b00,
    LD_LVL_OL  = 2'b01,
    LD_IDX_CNT = 2'b10,
    LD_IDX_OL  = 2'b11
  } ld_mode_e;

  typedef enum logic [1:0] {
    RS_LVL  = 2'b00,
    RS_GATE = 2'b01,
    RS_IDX  = 2'b10,
    RS_NONE = 2'b11
  } rs_mode_e;

  // Index level test: active when the pin equals the programmed level.
  function automatic logic idx_is_active(input logic lvl, input logic hi_act);
    return lvl == hi_act;
  endfunction

  // Level-driven functions are fixed active-low.
  function automatic logic lvl_is_active(input logic lvl);
    return !lvl;
  endfunction

endpackage

// File: rtl/index_sync.sv
module index_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= RST_VAL;
        else        sr <= d;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= {STAGES{RST_VAL}};
        else        sr <= {sr[STAGES-2:0], d};
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/index_arm.sv
module index_arm
  import index_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic lvl,
  input  logic hi_act,
  input  logic qevt,
  output logic fire
);
  logic armed;
  logic idx_act;

  assign idx_act = idx_is_active(lvl, hi_act);
  assign fire    = en && qevt && armed && idx_act;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        armed <= 1'b1;
    else if (!idx_act) armed <= 1'b1;
    else if (fire)     armed <= 1'b0;

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire); // R5

  AST_REARM_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_act |=> armed); // R5
endmodule

// File: rtl/index_ctl.sv
module index_ctl
  import index_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_pin,
  input  logic       rs_pin,
  input  logic [1:0] cfg_ld_mode,
  input  logic [1:0] cfg_rs_mode,
  input  logic       cfg_idx_pol,
  input  logic       cfg_quad,
  input  logic       qevt,
  output logic       cnt_load,
  output logic       ol_load,
  output logic       cnt_reset,
  output logic       cnt_en
);
  ld_mode_e ld_mode;
  rs_mode_e rs_mode;
  logic s_ld, s_rs;
  logic ld_idx_en, rs_idx_en;
  logic ld_fire, rs_fire;
  logic req_cnt_load, req_ol_load, req_reset, en_nxt;

  assign ld_mode = ld_mode_e'(cfg_ld_mode);
  assign rs_mode = rs_mode_e'(cfg_rs_mode);

  index_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ld (
    .clk(clk), .rst_n(rst_n), .d(ld_pin), .q(s_ld));
  index_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_rs (
    .clk(clk), .rst_n(rst_n), .d(rs_pin), .q(s_rs));

  // Index-tied functions only exist in quadrature mode.
  assign ld_idx_en = cfg_quad && ((ld_mode == LD_IDX_CNT) || (ld_mode == LD_IDX_OL));
  assign rs_idx_en = cfg_quad && (rs_mode == RS_IDX);

  index_arm u_arm_ld (
    .clk(clk), .rst_n(rst_n), .en(ld_idx_en), .lvl(s_ld),
    .hi_act(cfg_idx_pol), .qevt(qevt), .fire(ld_fire));
  index_arm u_arm_rs (
    .clk(clk), .rst_n(rst_n), .en(rs_idx_en), .lvl(s_rs),
    .hi_act(cfg_idx_pol), .qevt(qevt), .fire(rs_fire));

  always_comb begin
    req_cnt_load = ((ld_mode == LD_LVL_CNT) && lvl_is_active(s_ld)) ||
                   ((ld_mode == LD_IDX_CNT) && ld_fire);
    req_ol_load  = ((ld_mode == LD_LVL_OL)  && lvl_is_active(s_ld)) ||
                   ((ld_mode == LD_IDX_OL)  && ld_fire);
    req_reset    = ((rs_mode == RS_LVL) && lvl_is_active(s_rs)) || rs_fire;
    en_nxt       = (rs_mode == RS_GATE) ? s_rs : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_load  <= 1'b0;
      ol_load   <= 1'b0;
      cnt_reset <= 1'b0;
      cnt_en    <= 1'b0;
    end else begin
      cnt_reset <= req_reset;
      cnt_load  <= req_cnt_load && !req_reset;
      ol_load   <= req_ol_load;
      cnt_en    <= en_nxt;
    end

  AST_RESET_BEATS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_reset |-> !cnt_load); // R10

  AST_NONQUAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_quad && cfg_ld_mode[1]) |=> !(cnt_load || ol_load)); // R9

  AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_mode == RS_GATE && !s_rs) |=> !cnt_en); // R8

  AST_IDX_RESET_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_reset && $past(cfg_rs_mode) == 2'b10) |-> $past(qevt)); // R7

  AST_NONE_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_mode == RS_NONE) |=> (!cnt_reset && cnt_en)); // R11
endmodule

// File: tb/index_ctl_tb_top.sv
module index_ctl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ld_pin, rs_pin;
  logic [1:0] cfg_ld_mode, cfg_rs_mode;
  logic       cfg_idx_pol, cfg_quad, qevt;
  logic       cnt_load, ol_load, cnt_reset, cnt_en;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  index_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .ld_pin(ld_pin), .rs_pin(rs_pin),
    .cfg_ld_mode(cfg_ld_mode), .cfg_rs_mode(cfg_rs_mode),
    .cfg_idx_pol(cfg_idx_pol), .cfg_quad(cfg_quad), .qevt(qevt),
    .cnt_load(cnt_load), .ol_load(ol_load), .cnt_reset(cnt_reset),
    .cnt_en(cnt_en));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    ld_pin = 1'b1; rs_pin = 1'b1; qevt = 1'b0;
    cfg_ld_mode = 2'b00; cfg_rs_mode = 2'b11; cfg_idx_pol = 1'b0; cfg_quad = 1'b1;
    tick(4);
  endtask

  task automatic pulse_qevt();
    qevt = 1'b1; tick(1); qevt = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; idle();
    chk("R1", "cnt_load in reset", cnt_load, 1'b0);
    chk("R1", "ol_load in reset", ol_load, 1'b0);
    chk("R1", "cnt_reset in reset", cnt_reset, 1'b0);
    chk("R1", "cnt_en in reset", cnt_en, 1'b0);
    rst_n = 1'b1; tick(1);
  endtask

  task automatic t_lvl_cnt();
    idle(); cfg_ld_mode = 2'b00;
    ld_pin = 1'b0; tick(2);
    chk("R2", "cnt_load not early", cnt_load, 1'b0);
    tick(1);
    chk("R2", "cnt_load on 3rd edge", cnt_load, 1'b1);
    chk("R2", "ol_load idle", ol_load, 1'b0);
    tick(2);
    chk("R2", "cnt_load held", cnt_load, 1'b1);
    ld_pin = 1'b1; tick(3);
    chk("R2", "cnt_load released", cnt_load, 1'b0);
  endtask

  task automatic t_lvl_ol();
    idle(); cfg_ld_mode = 2'b01;
    ld_pin = 1'b0; tick(3);
    chk("R3", "ol_load", ol_load, 1'b1);
    chk("R3", "cnt_load idle", cnt_load, 1'b0);
    ld_pin = 1'b1; tick(3);
    chk("R3", "ol_load released", ol_load, 1'b0);
  endtask

  task automatic t_lvl_pol_ignored();
    idle(); cfg_ld_mode = 2'b00; cfg_idx_pol = 1'b1;
    ld_pin = 1'b1; tick(3);
    chk("R6", "level mode ignores pol (high)", cnt_load, 1'b0);
    ld_pin = 1'b0; tick(3);
    chk("R6", "level mode low active with pol=1", cnt_load, 1'b1);
  endtask

  task automatic t_idx_cnt();
    idle(); cfg_idx_pol = 1'b1; ld_pin = 1'b0; cfg_ld_mode = 2'b10; tick(3);
    ld_pin = 1'b1; tick(4);
    chk("R4", "no fire without qevt", cnt_load, 1'b0);
    pulse_qevt();
    chk("R4", "index counter load pulse", cnt_load, 1'b1);
    chk("R4", "ol_load idle", ol_load, 1'b0);
    tick(1);
    chk("R4", "pulse one cycle", cnt_load, 1'b0);
    pulse_qevt();
    chk("R5", "second qevt same index", cnt_load, 1'b0);
    ld_pin = 1'b0; tick(3);
    ld_pin = 1'b1; tick(2);
    pulse_qevt();
    chk("R5", "rearmed after idle", cnt_load, 1'b1);
  endtask

  task automatic t_idx_ol_low();
    idle(); cfg_ld_mode = 2'b11; cfg_idx_pol = 1'b0; tick(1);
    ld_pin = 1'b0; tick(2);
    pulse_qevt();
    chk("R6", "low-active index latch load", ol_load, 1'b1);
    chk("R4", "cnt_load idle in latch mode", cnt_load, 1'b0);
    ld_pin = 1'b1; tick(2);
    pulse_qevt();
    chk("R6", "high level inactive with pol=0", ol_load, 1'b0);
  endtask

  task automatic t_nonquad();
    idle(); cfg_quad = 1'b0; cfg_ld_mode = 2'b10; cfg_rs_mode = 2'b10;
    ld_pin = 1'b0; rs_pin = 1'b0; tick(3);
    pulse_qevt();
    chk("R9", "no index load", cnt_load, 1'b0);
    chk("R9", "no index reset", cnt_reset, 1'b0);
  endtask

  task automatic t_rs_lvl();
    idle(); cfg_rs_mode = 2'b00;
    rs_pin = 1'b0; tick(2);
    chk("R7", "reset not early", cnt_reset, 1'b0);
    tick(1);
    chk("R7", "level reset", cnt_reset, 1'b1);
    chk("R8", "cnt_en in level reset mode", cnt_en, 1'b1);
    rs_pin = 1'b1; tick(3);
    chk("R7", "level reset released", cnt_reset, 1'b0);
  endtask

  task automatic t_rs_idx();
    idle(); cfg_idx_pol = 1'b1; rs_pin = 1'b0; cfg_rs_mode = 2'b10; tick(3);
    rs_pin = 1'b1; tick(2);
    chk("R7", "no index reset without qevt", cnt_reset, 1'b0);
    pulse_qevt();
    chk("R7", "index reset pulse", cnt_reset, 1'b1);
    tick(1);
    chk("R7", "index reset one cycle", cnt_reset, 1'b0);
  endtask

  task automatic t_gate();
    idle(); cfg_rs_mode = 2'b01;
    rs_pin = 1'b1; tick(3);
    chk("R8", "gate open", cnt_en, 1'b1);
    rs_pin = 1'b0; tick(2);
    chk("R8", "gate close latency", cnt_en, 1'b1);
    tick(1);
    chk("R8", "gate closed", cnt_en, 1'b0);
    chk("R8", "no reset in gate mode", cnt_reset, 1'b0);
    rs_pin = 1'b1; tick(3);
    chk("R8", "gate reopened", cnt_en, 1'b1);
  endtask

  task automatic t_rs_none();
    idle(); cfg_rs_mode = 2'b11;
    rs_pin = 1'b0; tick(3);
    pulse_qevt();
    chk("R11", "no reset in none mode", cnt_reset, 1'b0);
    chk("R11", "enable in none mode", cnt_en, 1'b1);
  endtask

  task automatic t_priority();
    idle(); cfg_rs_mode = 2'b00; cfg_ld_mode = 2'b00;
    rs_pin = 1'b0; ld_pin = 1'b0; tick(3);
    chk("R10", "reset wins", cnt_reset, 1'b1);
    chk("R10", "load suppressed", cnt_load, 1'b0);
    cfg_ld_mode = 2'b01; tick(1);
    chk("R10", "latch load unaffected", ol_load, 1'b1);
    rs_pin = 1'b1; cfg_ld_mode = 2'b00; tick(3);
    chk("R10", "load returns after reset", cnt_load, 1'b1);
  endtask

  initial begin
    t_reset();
    t_lvl_cnt();
    t_lvl_ol();
    t_lvl_pol_ignored();
    t_idx_cnt();
    t_idx_ol_low();
    t_nonquad();
    t_rs_lvl();
    t_rs_idx();
    t_gate();
    t_rs_none();
    t_priority();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule